// File: doc/BRIEF.md
# Interrupt Controller Command-Word Sequencer

This block is the write-side front end of an eight-input programmable interrupt controller. A processor writes bytes through a small port: an 8-bit data bus, one address line and a write strobe. Each write is sorted into one of three kinds. It can be an initialization word, a mask load, or a command that goes on to the interrupt core. A four-step initialization sequence sets the trigger style, whether the controller is alone or cascaded, the vector base, the cascade wiring and the end-of-interrupt style. Whether the third and fourth steps occur depends on flags carried by the first step.

After initialization, data-port writes load the interrupt mask. Command-port writes become one-cycle end-of-interrupt requests toward the interrupt core. All configuration is held in registers and presented as level outputs. The cascade-position input tells the block whether the third step describes attached slaves (master) or this unit's own identity (slave).

Top module: `pic_cfg_seq`

## Requirements
- R1: After reset the sequencer is idle, `irq_mask` is 8'hFF, `init_busy` is 0, and all other configuration outputs, `eoi_valid` and `clear_service` are 0.
- R2: A write with `addr0`=0 and `wdata[4]`=1 restarts initialization from any state. After that write, `init_busy`=1, `irq_mask`=0, `auto_eoi`=0 and `clear_service` pulses for one cycle. It also sets `level_trig` from `wdata[3]` and `single_mode` from `wdata[1]`, and records `wdata[0]` as "fourth word needed".
- R3: The first `addr0`=1 write after the restart loads `vector_base` from `wdata[7:3]`.
- R4: When `single_mode`=0 and `is_slave`=0, the next `addr0`=1 write loads the whole byte into `cascade_map`. When `single_mode`=1 this step is skipped.
- R5: When `single_mode`=0 and `is_slave`=1, that same step loads `slave_id` from `wdata[2:0]` and leaves `cascade_map` unchanged.
- R6: When the recorded fourth-word flag is 1, the next `addr0`=1 write loads `auto_eoi` from `wdata[1]`. When the flag is 0 this step is skipped.
- R7: `init_busy` falls right after the last expected word. With `single_mode`=1 and no fourth word, that is the vector-base write.
- R8: Once initialization is complete, every `addr0`=1 write loads `irq_mask` with the full byte.
- R9: `addr0`=1 writes made before any initialization also load `irq_mask`.
- R10: Once initialization is complete, a write with `addr0`=0 and `wdata[4]`=0 gives a one-cycle `eoi_valid` pulse, with `eoi_cmd`=`wdata[7:5]` and `eoi_level`=`wdata[2:0]`.
- R11: A write with `addr0`=0 and `wdata[4]`=0 made while `init_busy`=1, or before any initialization, produces no `eoi_valid` pulse and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr0 | input | 1 | Port select: 0 command port, 1 data port |
| wdata | input | 8 | Write data |
| is_slave | input | 1 | 1 when this unit is a cascaded slave |
| level_trig | output | 1 | 1 level triggering, 0 edge triggering |
| single_mode | output | 1 | 1 lone controller, 0 cascaded |
| vector_base | output | 5 | Upper vector bits |
| cascade_map | output | 8 | Inputs that have slaves attached (master) |
| slave_id | output | 3 | Own identity number (slave) |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| irq_mask | output | 8 | Interrupt mask, 1 blocks an input |
| init_busy | output | 1 | Initialization sequence in progress |
| clear_service | output | 1 | One-cycle pulse clearing in-service state |
| eoi_valid | output | 1 | One-cycle end-of-interrupt request |
| eoi_cmd | output | 3 | End-of-interrupt command type |
| eoi_level | output | 3 | End-of-interrupt level |

## Verification
The hardest case to reach is a restart that lands partway through a sequence, for example during the third or fourth step. The sequencer then has to discard the old step flags and take new ones. Random stimulus reaches it by making about a fifth of all writes restart words with random flag bits, mixed with random command and data writes. The position input is toggled between sequences so that both meanings of the third step are exercised. A reference model in the bench follows every write.

// File: rtl/pic_cfg_pkg.sv
package pic_cfg_pkg;
  // Bit positions inside the first initialization word
  localparam int unsigned B_INIT = 4;
  localparam int unsigned B_LTIM = 3;
  localparam int unsigned B_SNGL = 1;
  localparam int unsigned B_IC4  = 0;
  // Auto end-of-interrupt bit in the fourth word
  localparam int unsigned B_AEOI = 1;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_W2    = 3'd1,
    ST_W3    = 3'd2,
    ST_W4    = 3'd3,
    ST_READY = 3'd4
  } seq_t;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_INIT = 2'd1,
    WK_CMD  = 2'd2,
    WK_DATA = 2'd3
  } wkind_t;
endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
  import pic_cfg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          wr_en,
  input  logic          addr0,
  input  logic [DW-1:0] wdata,
  output wkind_t        kind
);
  always_comb begin
    if (!wr_en)               kind = WK_NONE;
    else if (addr0)           kind = WK_DATA;
    else if (wdata[B_INIT])   kind = WK_INIT;
    else                      kind = WK_CMD;
  end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_cfg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wkind_t        kind,
  input  logic [DW-1:0] wdata,
  output seq_t          st,
  output logic          ld_init,
  output logic          ld_w2,
  output logic          ld_w3,
  output logic          ld_w4,
  output logic          ld_mask,
  output logic          eoi_go
);
  seq_t st_n;
  logic need3, need3_n, need4, need4_n;

  always_comb begin
    st_n    = st;
    need3_n = need3;
    need4_n = need4;
    ld_init = 1'b0;
    ld_w2   = 1'b0;
    ld_w3   = 1'b0;
    ld_w4   = 1'b0;
    ld_mask = 1'b0;
    eoi_go  = 1'b0;
    case (kind)
      WK_INIT: begin
        ld_init = 1'b1;
        st_n    = ST_W2;
        need3_n = ~wdata[B_SNGL];
        need4_n = wdata[B_IC4];
      end
      WK_DATA: begin
        case (st)
          ST_W2: begin
            ld_w2 = 1'b1;
            st_n  = need3 ? ST_W3 : (need4 ? ST_W4 : ST_READY);
          end
          ST_W3: begin
            ld_w3 = 1'b1;
            st_n  = need4 ? ST_W4 : ST_READY;
          end
          ST_W4: begin
            ld_w4 = 1'b1;
            st_n  = ST_READY;
          end
          default: ld_mask = 1'b1;
        endcase
      end
      WK_CMD: eoi_go = (st == ST_READY);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      need3 <= 1'b0;
      need4 <= 1'b0;
    end else begin
      st    <= st_n;
      need3 <= need3_n;
      need4 <= need4_n;
    end
  end

  // R2
  restart_to_w2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind == WK_INIT |=> st == ST_W2);
  // R7
  short_seq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_W2 && kind == WK_DATA && !need3 && !need4) |=> st == ST_READY);
  // R6
  w4_after_w3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_W3 && kind == WK_DATA && need4) |=> st == ST_W4);
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_cfg_pkg::*;
#(
  parameter int DW   = 8,
  parameter int N_IN = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            wdata,
  input  logic                     is_slave,
  input  logic                     ld_init,
  input  logic                     ld_w2,
  input  logic                     ld_w3,
  input  logic                     ld_w4,
  input  logic                     ld_mask,
  input  logic                     eoi_go,
  output logic                     level_trig,
  output logic                     single_mode,
  output logic [DW-$clog2(N_IN)-1:0] vector_base,
  output logic [N_IN-1:0]          cascade_map,
  output logic [$clog2(N_IN)-1:0]  slave_id,
  output logic                     auto_eoi,
  output logic [N_IN-1:0]          irq_mask,
  output logic                     clear_service,
  output logic                     eoi_valid,
  output logic [2:0]               eoi_cmd,
  output logic [$clog2(N_IN)-1:0]  eoi_level
);
  localparam int IW = $clog2(N_IN);
  localparam int VW = DW - IW;

  logic ld_casc, ld_sid;
  assign ld_casc = ld_w3 & ~is_slave;
  assign ld_sid  = ld_w3 & is_slave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_trig  <= 1'b0;
      single_mode <= 1'b0;
    end else if (ld_init) begin
      level_trig  <= wdata[B_LTIM];
      single_mode <= wdata[B_SNGL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vector_base <= '0;
    else if (ld_w2) vector_base <= wdata[DW-1:IW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cascade_map <= '0;
    else if (ld_casc) cascade_map <= wdata[N_IN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      slave_id <= '0;
    else if (ld_sid) slave_id <= wdata[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       auto_eoi <= 1'b0;
    else if (ld_init) auto_eoi <= 1'b0;
    else if (ld_w4)   auto_eoi <= wdata[B_AEOI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_mask <= '1;
    else if (ld_init) irq_mask <= '0;
    else if (ld_mask) irq_mask <= wdata[N_IN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clear_service <= 1'b0;
      eoi_valid     <= 1'b0;
    end else begin
      clear_service <= ld_init;
      eoi_valid     <= eoi_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_cmd   <= '0;
      eoi_level <= '0;
    end else if (eoi_go) begin
      eoi_cmd   <= wdata[DW-1:DW-3];
      eoi_level <= wdata[IW-1:0];
    end
  end

  // R5
  slave_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_w3 && is_slave) |=> $stable(cascade_map));
  // R10
  eoi_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !eoi_go) |=> !eoi_valid);
endmodule

// File: rtl/pic_cfg_seq.sv
module pic_cfg_seq
  import pic_cfg_pkg::*;
#(
  parameter int DW   = 8,
  parameter int N_IN = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          addr0,
  input  logic [DW-1:0]                 wdata,
  input  logic                          is_slave,
  output logic                          level_trig,
  output logic                          single_mode,
  output logic [DW-$clog2(N_IN)-1:0]    vector_base,
  output logic [N_IN-1:0]               cascade_map,
  output logic [$clog2(N_IN)-1:0]       slave_id,
  output logic                          auto_eoi,
  output logic [N_IN-1:0]               irq_mask,
  output logic                          init_busy,
  output logic                          clear_service,
  output logic                          eoi_valid,
  output logic [2:0]                    eoi_cmd,
  output logic [$clog2(N_IN)-1:0]       eoi_level
);
  wkind_t kind;
  seq_t   st;
  logic   ld_init, ld_w2, ld_w3, ld_w4, ld_mask, eoi_go;

  pic_wr_decode #(.DW(DW)) u_dec (
    .wr_en (wr_en),
    .addr0 (addr0),
    .wdata (wdata),
    .kind  (kind)
  );

  pic_init_fsm #(.DW(DW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .wdata   (wdata),
    .st      (st),
    .ld_init (ld_init),
    .ld_w2   (ld_w2),
    .ld_w3   (ld_w3),
    .ld_w4   (ld_w4),
    .ld_mask (ld_mask),
    .eoi_go  (eoi_go)
  );

  pic_cfg_regs #(.DW(DW), .N_IN(N_IN)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdata         (wdata),
    .is_slave      (is_slave),
    .ld_init       (ld_init),
    .ld_w2         (ld_w2),
    .ld_w3         (ld_w3),
    .ld_w4         (ld_w4),
    .ld_mask       (ld_mask),
    .eoi_go        (eoi_go),
    .level_trig    (level_trig),
    .single_mode   (single_mode),
    .vector_base   (vector_base),
    .cascade_map   (cascade_map),
    .slave_id      (slave_id),
    .auto_eoi      (auto_eoi),
    .irq_mask      (irq_mask),
    .clear_service (clear_service),
    .eoi_valid     (eoi_valid),
    .eoi_cmd       (eoi_cmd),
    .eoi_level     (eoi_level)
  );

  assign init_busy = (st == ST_W2) || (st == ST_W3) || (st == ST_W4);

  // R2
  init_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr0 && wdata[B_INIT]) |=> (irq_mask == '0 && init_busy && clear_service));
  // R11
  no_eoi_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !init_busy);
  // R8
  mask_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(irq_mask));
  // R7
  busy_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(init_busy));
endmodule

// File: tb/pic_cfg_seq_test.sv
module pic_cfg_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic addr0 = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic is_slave = 1'b0;

  logic       level_trig, single_mode, auto_eoi, init_busy, clear_service, eoi_valid;
  logic [4:0] vector_base;
  logic [7:0] cascade_map, irq_mask;
  logic [2:0] slave_id, eoi_cmd, eoi_level;

  int checks = 0;
  int errors = 0;

  pic_cfg_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr0(addr0), .wdata(wdata),
    .is_slave(is_slave), .level_trig(level_trig), .single_mode(single_mode),
    .vector_base(vector_base), .cascade_map(cascade_map), .slave_id(slave_id),
    .auto_eoi(auto_eoi), .irq_mask(irq_mask), .init_busy(init_busy),
    .clear_service(clear_service), .eoi_valid(eoi_valid), .eoi_cmd(eoi_cmd),
    .eoi_level(eoi_level)
  );

  always #10 clk = ~clk;

  // reference model: 0 idle, 1 w2, 2 w3, 3 w4, 4 ready
  int         m_st;
  logic       m_n3, m_n4, m_lt, m_sg, m_ae, m_clr, m_ev;
  logic [4:0] m_vb;
  logic [7:0] m_cm, m_mk;
  logic [2:0] m_sid, m_ec, m_el;

  function automatic int next_after_w2(logic n3, logic n4);
    return n3 ? 2 : (n4 ? 3 : 4);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_n3 = 0; m_n4 = 0; m_lt = 0; m_sg = 0; m_ae = 0; m_clr = 0; m_ev = 0;
    m_vb = 0; m_cm = 0; m_mk = 8'hFF; m_sid = 0; m_ec = 0; m_el = 0;
  endtask

  function automatic string model_apply(logic a0, logic [7:0] d);
    string tag;
    m_clr = 0; m_ev = 0; tag = "R11";
    if (!a0 && d[4]) begin
      tag = "R2"; m_st = 1; m_n3 = ~d[1]; m_n4 = d[0]; m_lt = d[3]; m_sg = d[1];
      m_mk = 0; m_ae = 0; m_clr = 1;
    end else if (a0) begin
      case (m_st)
        1: begin tag = "R3"; m_vb = d[7:3]; m_st = next_after_w2(m_n3, m_n4); end
        2: begin
          if (is_slave) begin tag = "R5"; m_sid = d[2:0]; end
          else begin tag = "R4"; m_cm = d; end
          m_st = m_n4 ? 3 : 4;
        end
        3: begin tag = "R6"; m_ae = d[1]; m_st = 4; end
        4: begin tag = "R8"; m_mk = d; end
        default: begin tag = "R9"; m_mk = d; end
      endcase
    end else if (m_st == 4) begin
      tag = "R10"; m_ev = 1; m_ec = d[7:5]; m_el = d[2:0];
    end
    return tag;
  endfunction

  task automatic compare_all(string tag);
    chk(tag, "level_trig", level_trig, m_lt);
    chk(tag, "single_mode", single_mode, m_sg);
    chk(tag, "vector_base", vector_base, m_vb);
    chk(tag, "cascade_map", cascade_map, m_cm);
    chk(tag, "slave_id", slave_id, m_sid);
    chk(tag, "auto_eoi", auto_eoi, m_ae);
    chk(tag, "irq_mask", irq_mask, m_mk);
    chk(tag, "init_busy", init_busy, (m_st >= 1 && m_st <= 3) ? 1 : 0);
    chk(tag, "clear_service", clear_service, m_clr);
    chk(tag, "eoi_valid", eoi_valid, m_ev);
    if (m_ev) begin
      chk(tag, "eoi_cmd", eoi_cmd, m_ec);
      chk(tag, "eoi_level", eoi_level, m_el);
    end
  endtask

  // drive at a falling edge, captured at the rising edge, sampled at the next falling edge
  task automatic wr(logic a0, logic [7:0] d);
    string tag;
    @(negedge clk);
    wr_en = 1'b1; addr0 = a0; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    tag = model_apply(a0, d);
    compare_all(tag);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R11: command before any init is ignored; R9: mask before init stored
    wr(1'b0, 8'h20);
    wr(1'b1, 8'h5A);

    // short sequence: single, no fourth word -> busy drops after vector word (R7)
    wr(1'b0, 8'h1A);
    wr(1'b1, 8'h48);
    chk("R7", "init_busy after last word", init_busy, 0);
    wr(1'b1, 8'hC3);
    wr(1'b0, 8'h65);

    // full master sequence with command inside init (R11)
    is_slave = 1'b0;
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b0, 8'h20);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h03);
    chk("R7", "init_busy after fourth word", init_busy, 0);

    // slave sequence, restarted in the middle of the third step
    is_slave = 1'b1;
    wr(1'b0, 8'h19);
    wr(1'b1, 8'h70);
    wr(1'b0, 8'h13);
    wr(1'b1, 8'hF8);
    wr(1'b1, 8'h02);
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'hE7);

    for (int i = 0; i < 1500; i++) begin
      int r;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      d = 8'($urandom);
      if (r < 20) begin
        if ($urandom_range(0, 3) == 0) is_slave = ~is_slave;
        wr(1'b0, d | 8'h10);
      end else if (r < 40) wr(1'b0, d & 8'hEF);
      else wr(1'b1, d);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule